// File: doc/BRIEF.md
# EEPROM Access and Burst Controller

This block lets a host move bytes to and from an external EEPROM through a handful of registers. It also copies tables out of the EEPROM into on-chip memory on its own. The EEPROM is reached through a simple byte port with a request/acknowledge handshake. Any serial signalling behind that port belongs to another block.

A single access uses the address and data registers. A read request fetches the byte at the address register into the data register. A write request sends the low byte of the data register to that address. Each request bit stays set while its transfer runs and clears itself when the transfer ends, so the host polls it.

A burst copy walks the EEPROM from a start pointer. The pointer is zero after reset and otherwise follows the last byte touched. The copy reads records of three bytes: a 16-bit address, low byte first, then one data byte. Each data byte is written into memory at an address built from the base register and the lower 15 bits of the record address. A record address of 0xFFFF ends the copy.

Top module: `eebc_top`

## Requirements
- R1: After reset every host register reads 0, `ee_req` is low and `mem_we` is low.
- R2: Writing a 1 to bit 1 of the control register (select 0) starts a read. The byte at the address register (select 1) is loaded into the data register (select 2). Bit 1 reads 1 until the byte is loaded, then reads 0.
- R3: Writing a 1 to bit 0 of the control register starts a write. The low byte of the data register goes to the EEPROM at the address register. Bit 0 reads 0 once the EEPROM has acknowledged the write.
- R4: `ee_req` stays high, with `ee_addr`, `ee_we` and `ee_wdata` held steady, until `ee_ack` is seen. Exactly one byte moves per acknowledge.
- R5: Writing a 1 to bit 0 of the start register (select 4) begins a burst. The burst reads records of low address byte, high address byte and data byte from consecutive EEPROM addresses. It ends, and bit 0 reads 0, after a record address of 0xFFFF.
- R6: A burst begins at EEPROM address 0 if no earlier access has happened since reset. Otherwise it begins one past the last EEPROM address read or written by any operation, including an earlier burst.
- R7: Each data byte of a burst produces exactly one `mem_we` pulse. `mem_addr` carries the base register (select 3, 9 bits) in bits [23:15] and record address bits [14:0] in bits [14:0]. Record address bit 15 is ignored.
- R8: Only one operation runs at a time. Control or start writes made while any request or start bit is set are dropped, with no EEPROM or memory traffic resulting from them.
- R9: If one control write sets both bit 1 and bit 0, only the read is performed. The write request is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 3 | Register select: 0 control, 1 address, 2 data, 3 base, 4 start |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the selected register |
| ee_req | output | 1 | EEPROM byte transfer request |
| ee_we | output | 1 | 1 = write transfer, 0 = read transfer |
| ee_addr | output | 16 | EEPROM byte address |
| ee_wdata | output | 8 | Byte to write |
| ee_ack | input | 1 | EEPROM transfer done |
| ee_rdata | input | 8 | Byte read, valid with `ee_ack` |
| mem_we | output | 1 | Memory write strobe, one cycle per burst data byte |
| mem_addr | output | 24 | Memory write address |
| mem_wdata | output | 8 | Memory write data |

## Verification
A wrong start pointer shows up at the first EEPROM request of a burst, as an `ee_addr` other than 0 or one past the last access. Every memory address of that burst then shifts with it. A fault in record assembly, or a bit 15 that is not dropped, gives a wrong `mem_addr` on the first `mem_we` pulse. A missed 0xFFFF check leaves the start bit set, so the burst keeps reading past the terminator. A broken busy interlock shows as an extra EEPROM write or a `mem_we` pulse after a request that should have been dropped. It also shows as a control read that does not show the operation still pending.

// File: rtl/eebc_pkg.sv
package eebc_pkg;
    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_ADDR  = 3'd1;
    localparam logic [2:0] SEL_DATA  = 3'd2;
    localparam logic [2:0] SEL_BASE  = 3'd3;
    localparam logic [2:0] SEL_START = 3'd4;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_SINGLE = 2'd1,
        MODE_BURST  = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        PH_ALO = 2'd0,
        PH_AHI = 2'd1,
        PH_DAT = 2'd2
    } phase_e;
endpackage

// File: rtl/eebc_port.sv
module eebc_port #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          we_in,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdata_in,
    output logic          ee_req,
    output logic          ee_we,
    output logic [AW-1:0] ee_addr,
    output logic [DW-1:0] ee_wdata,
    input  logic          ee_ack,
    input  logic [DW-1:0] ee_rdata,
    output logic          done,
    output logic [DW-1:0] rdata
);
    typedef struct packed {
        logic          req;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          done;
        logic [DW-1:0] rdata;
    } port_st_t;

    port_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.req) begin
            if (ee_ack) begin
                st_d.req  = 1'b0;
                st_d.done = 1'b1;
                if (!st_q.we) begin
                    st_d.rdata = ee_rdata;
                end
            end
        end else if (start) begin
            st_d.req   = 1'b1;
            st_d.we    = we_in;
            st_d.addr  = addr_in;
            st_d.wdata = wdata_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ee_req   = st_q.req;
    assign ee_we    = st_q.we;
    assign ee_addr  = st_q.addr;
    assign ee_wdata = st_q.wdata;
    assign done     = st_q.done;
    assign rdata    = st_q.rdata;
endmodule

// File: rtl/eebc_regs.sv
module eebc_regs #(
    parameter int AW     = 16,
    parameter int DW     = 8,
    parameter int BASE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr,
    input  logic              wr_data,
    input  logic              wr_base,
    input  logic [AW-1:0]     wval_addr,
    input  logic [DW-1:0]     wval_data,
    input  logic [BASE_W-1:0] wval_base,
    input  logic              load_data,
    input  logic [DW-1:0]     load_val,
    output logic [AW-1:0]     addr_q,
    output logic [DW-1:0]     data_q,
    output logic [BASE_W-1:0] base_q
);
    typedef struct packed {
        logic [AW-1:0]     addr;
        logic [DW-1:0]     data;
        logic [BASE_W-1:0] base;
    } regs_st_t;

    regs_st_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (wr_addr) begin
            rg_d.addr = wval_addr;
        end
        if (wr_data) begin
            rg_d.data = wval_data;
        end
        if (wr_base) begin
            rg_d.base = wval_base;
        end
        if (load_data) begin
            rg_d.data = load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign addr_q = rg_q.addr;
    assign data_q = rg_q.data;
    assign base_q = rg_q.base;
endmodule

// File: rtl/eebc_seq.sv
module eebc_seq
    import eebc_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 8,
    parameter int MEM_AW = 24,
    parameter int BASE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_set,
    input  logic [1:0]        ctrl_bits,
    input  logic              go_set,
    input  logic [AW-1:0]     addr_reg,
    input  logic [DW-1:0]     data_reg,
    input  logic [BASE_W-1:0] base_reg,
    output logic              p_start,
    output logic              p_we,
    output logic [AW-1:0]     p_addr,
    output logic [DW-1:0]     p_wdata,
    input  logic              p_done,
    input  logic [DW-1:0]     p_rdata,
    output logic              load_data,
    output logic [DW-1:0]     load_val,
    output logic              rd_bit,
    output logic              wr_bit,
    output logic              go_bit,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata
);
    localparam int LOW_W = MEM_AW - BASE_W;
    localparam int WW    = 2 * DW;

    typedef struct packed {
        mode_e             mode;
        phase_e            phase;
        logic              pend;
        logic              rd;
        logic              wr;
        logic              go;
        logic [AW-1:0]     ptr;
        logic [WW-1:0]     word;
        logic              mwe;
        logic [MEM_AW-1:0] maddr;
        logic [DW-1:0]     mdata;
    } seq_st_t;

    seq_st_t sq_d, sq_q;

    always_comb begin
        sq_d      = sq_q;
        sq_d.mwe  = 1'b0;
        p_start   = 1'b0;
        p_we      = 1'b0;
        p_addr    = sq_q.ptr;
        p_wdata   = data_reg;
        load_data = 1'b0;
        load_val  = p_rdata;
        unique case (sq_q.mode)
            MODE_IDLE: begin
                if (ctrl_set && (ctrl_bits != 2'b00)) begin
                    sq_d.rd   = ctrl_bits[1];
                    sq_d.wr   = !ctrl_bits[1];
                    sq_d.pend = 1'b0;
                    sq_d.mode = MODE_SINGLE;
                end else if (go_set) begin
                    sq_d.go    = 1'b1;
                    sq_d.pend  = 1'b0;
                    sq_d.phase = PH_ALO;
                    sq_d.mode  = MODE_BURST;
                end
            end
            MODE_SINGLE: begin
                p_addr = addr_reg;
                p_we   = sq_q.wr;
                if (!sq_q.pend) begin
                    p_start   = 1'b1;
                    sq_d.pend = 1'b1;
                end else if (p_done) begin
                    load_data = sq_q.rd;
                    sq_d.pend = 1'b0;
                    sq_d.rd   = 1'b0;
                    sq_d.wr   = 1'b0;
                    sq_d.ptr  = addr_reg + AW'(1);
                    sq_d.mode = MODE_IDLE;
                end
            end
            MODE_BURST: begin
                if (!sq_q.pend) begin
                    p_start   = 1'b1;
                    sq_d.pend = 1'b1;
                end else if (p_done) begin
                    sq_d.pend = 1'b0;
                    sq_d.ptr  = sq_q.ptr + AW'(1);
                    unique case (sq_q.phase)
                        PH_ALO: begin
                            sq_d.word[DW-1:0] = p_rdata;
                            sq_d.phase        = PH_AHI;
                        end
                        PH_AHI: begin
                            if ({p_rdata, sq_q.word[DW-1:0]} == {WW{1'b1}}) begin
                                sq_d.go    = 1'b0;
                                sq_d.phase = PH_ALO;
                                sq_d.mode  = MODE_IDLE;
                            end else begin
                                sq_d.word[WW-1:DW] = p_rdata;
                                sq_d.phase         = PH_DAT;
                            end
                        end
                        default: begin
                            sq_d.mwe   = 1'b1;
                            sq_d.maddr = {base_reg, sq_q.word[LOW_W-1:0]};
                            sq_d.mdata = p_rdata;
                            sq_d.phase = PH_ALO;
                        end
                    endcase
                end
            end
            default: begin
                sq_d.mode = MODE_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign rd_bit    = sq_q.rd;
    assign wr_bit    = sq_q.wr;
    assign go_bit    = sq_q.go;
    assign mem_we    = sq_q.mwe;
    assign mem_addr  = sq_q.maddr;
    assign mem_wdata = sq_q.mdata;
endmodule

// File: rtl/eebc_top.sv
module eebc_top
    import eebc_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 8,
    parameter int MEM_AW = 24,
    parameter int BASE_W = 9,
    parameter int RW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [2:0]        host_sel,
    input  logic [RW-1:0]     host_wdata,
    output logic [RW-1:0]     host_rdata,
    output logic              ee_req,
    output logic              ee_we,
    output logic [AW-1:0]     ee_addr,
    output logic [DW-1:0]     ee_wdata,
    input  logic              ee_ack,
    input  logic [DW-1:0]     ee_rdata,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata
);
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     data_q;
    logic [BASE_W-1:0] base_q;
    logic              load_data;
    logic [DW-1:0]     load_val;
    logic              p_start, p_we, p_done;
    logic [AW-1:0]     p_addr;
    logic [DW-1:0]     p_wdata, p_rdata;
    logic              rd_bit, wr_bit, go_bit;
    logic              wdata_unused;

    assign wdata_unused = ^host_wdata[RW-1:AW];

    eebc_regs #(.AW(AW), .DW(DW), .BASE_W(BASE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_addr   (host_we && host_sel == SEL_ADDR),
        .wr_data   (host_we && host_sel == SEL_DATA),
        .wr_base   (host_we && host_sel == SEL_BASE),
        .wval_addr (host_wdata[AW-1:0]),
        .wval_data (host_wdata[DW-1:0]),
        .wval_base (host_wdata[BASE_W-1:0]),
        .load_data (load_data),
        .load_val  (load_val),
        .addr_q    (addr_q),
        .data_q    (data_q),
        .base_q    (base_q)
    );

    eebc_seq #(.AW(AW), .DW(DW), .MEM_AW(MEM_AW), .BASE_W(BASE_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_set  (host_we && host_sel == SEL_CTRL),
        .ctrl_bits (host_wdata[1:0]),
        .go_set    (host_we && host_sel == SEL_START && host_wdata[0]),
        .addr_reg  (addr_q),
        .data_reg  (data_q),
        .base_reg  (base_q),
        .p_start   (p_start),
        .p_we      (p_we),
        .p_addr    (p_addr),
        .p_wdata   (p_wdata),
        .p_done    (p_done),
        .p_rdata   (p_rdata),
        .load_data (load_data),
        .load_val  (load_val),
        .rd_bit    (rd_bit),
        .wr_bit    (wr_bit),
        .go_bit    (go_bit),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    eebc_port #(.AW(AW), .DW(DW)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (p_start),
        .we_in    (p_we),
        .addr_in  (p_addr),
        .wdata_in (p_wdata),
        .ee_req   (ee_req),
        .ee_we    (ee_we),
        .ee_addr  (ee_addr),
        .ee_wdata (ee_wdata),
        .ee_ack   (ee_ack),
        .ee_rdata (ee_rdata),
        .done     (p_done),
        .rdata    (p_rdata)
    );

    always_comb begin
        host_rdata = '0;
        unique case (host_sel)
            SEL_CTRL:  host_rdata[1:0]        = {rd_bit, wr_bit};
            SEL_ADDR:  host_rdata[AW-1:0]     = addr_q;
            SEL_DATA:  host_rdata[DW-1:0]     = data_q;
            SEL_BASE:  host_rdata[BASE_W-1:0] = base_q;
            SEL_START: host_rdata[0]          = go_bit;
            default:   host_rdata             = '0;
        endcase
    end
endmodule

// File: rtl/eebc_chk.sv
module eebc_chk #(
    parameter int AW     = 16,
    parameter int DW     = 8,
    parameter int MEM_AW = 24,
    parameter int BASE_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ee_req,
    input logic              ee_ack,
    input logic              ee_we,
    input logic [AW-1:0]     ee_addr,
    input logic [DW-1:0]     ee_wdata,
    input logic              mem_we,
    input logic [MEM_AW-1:0] mem_addr,
    input logic [BASE_W-1:0] base_q,
    input logic              rd_bit,
    input logic              wr_bit,
    input logic              go_bit
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && !ee_ack) |=> ee_req); // R4
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && !ee_ack) |=> ($stable(ee_addr) && $stable(ee_we) && $stable(ee_wdata))); // R4
    AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_bit, wr_bit, go_bit})); // R8
    AST_REQ_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        ee_req |-> (rd_bit || wr_bit || go_bit)); // R8
    AST_EE_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && ee_we) |-> wr_bit); // R3
    AST_MEMWE_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> go_bit); // R5
    AST_MEM_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[MEM_AW-1 -: BASE_W] == $past(base_q))); // R7
endmodule

bind eebc_top eebc_chk #(.AW(AW), .DW(DW), .MEM_AW(MEM_AW), .BASE_W(BASE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ee_req   (ee_req),
    .ee_ack   (ee_ack),
    .ee_we    (ee_we),
    .ee_addr  (ee_addr),
    .ee_wdata (ee_wdata),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .base_q   (base_q),
    .rd_bit   (rd_bit),
    .wr_bit   (wr_bit),
    .go_bit   (go_bit)
);

// File: tb/tb_eebc_top.sv
module tb_eebc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_sel = 3'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        ee_req, ee_we;
    logic [15:0] ee_addr;
    logic [7:0]  ee_wdata;
    logic        ee_ack = 1'b0;
    logic [7:0]  ee_rdata = '0;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    eebc_top dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr), .ee_wdata(ee_wdata),
        .ee_ack(ee_ack), .ee_rdata(ee_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // EEPROM model: 256 bytes, acknowledges after lat waiting cycles
    logic [7:0] emem [0:255];
    int  lat = 2;
    int  wcnt = 0;
    int  n_ack = 0;
    int  n_eewr = 0;
    logic       pl_we = 1'b0;
    logic [7:0] pl_addr = '0;
    logic [7:0] pl_data = '0;

    always @(posedge clk) begin
        ee_ack <= 1'b0;
        if (pl_we) emem[pl_addr] <= pl_data;
        if (ee_req && !ee_ack) begin
            if (wcnt >= lat) begin
                wcnt   <= 0;
                ee_ack <= 1'b1;
                n_ack  <= n_ack + 1;
                if (ee_we) begin
                    emem[ee_addr[7:0]] <= ee_wdata;
                    n_eewr <= n_eewr + 1;
                end else begin
                    ee_rdata <= emem[ee_addr[7:0]];
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    // monitors
    logic [23:0] mw_addr [0:15];
    logic [7:0]  mw_data [0:15];
    int          mw_n = 0;
    int          hs_err = 0;
    logic        pv_req = 1'b0, pv_ack = 1'b0;
    logic [15:0] pv_addr = '0;
    logic [15:0] first_addr = '0;
    bit          grab_first = 0;
    bit          got_first = 0;

    always @(negedge clk) begin
        if (mem_we && mw_n < 16) begin
            mw_addr[mw_n] = mem_addr;
            mw_data[mw_n] = mem_wdata;
            mw_n = mw_n + 1;
        end
        if (pv_req && !pv_ack && ee_req && (ee_addr != pv_addr)) hs_err = hs_err + 1;
        if (grab_first && !got_first && ee_req) begin
            first_addr = ee_addr;
            got_first = 1;
        end
        pv_req = ee_req;
        pv_ack = ee_ack;
        pv_addr = ee_addr;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [2:0] sel, input logic [31:0] val);
        @(negedge clk);
        host_sel = sel; host_wdata = val; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hr(input logic [2:0] sel, output logic [31:0] val);
        @(negedge clk);
        host_sel = sel;
        #1 val = host_rdata;
    endtask

    task automatic preload(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        pl_we = 1'b1; pl_addr = a; pl_data = v;
        @(negedge clk);
        pl_we = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] c, s;
        bit ok = 0;
        for (int i = 0; i < 3000; i++) begin
            hr(3'd0, c);
            hr(3'd4, s);
            if (c[1:0] == 2'b00 && s[0] == 1'b0) begin
                ok = 1;
                break;
            end
        end
        chk({tag, " idle reached"}, {31'b0, ok}, 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int s = 0; s < 5; s++) begin
            hr(3'(s), v);
            chk("R1 register reset value", v, 32'd0);
        end
        chk("R1 ee_req low", {31'b0, ee_req}, 32'd0);
        chk("R1 mem_we low", {31'b0, mem_we}, 32'd0);
    endtask

    task automatic t_burst_from_zero();
        int a0;
        preload(8'h00, 8'h23); preload(8'h01, 8'h81); preload(8'h02, 8'h5A);
        preload(8'h03, 8'h07); preload(8'h04, 8'h00); preload(8'h05, 8'hC3);
        preload(8'h06, 8'hFF); preload(8'h07, 8'hFF);
        hw(3'd3, 32'h1A5);
        a0 = n_ack;
        got_first = 0; grab_first = 1;
        hw(3'd4, 32'h1);
        wait_idle("R5 burst");
        grab_first = 0;
        chk("R6 first burst address after reset", {16'b0, first_addr}, 32'h0);
        chk("R5 bytes read by burst", n_ack - a0, 32'd8);
        chk("R7 memory write count", mw_n, 32'd2);
        chk("R7 first address, bit 15 dropped", {8'b0, mw_addr[0]}, {8'b0, 9'h1A5, 15'h0123});
        chk("R7 first data", {24'b0, mw_data[0]}, 32'h5A);
        chk("R7 second address", {8'b0, mw_addr[1]}, {8'b0, 9'h1A5, 15'h0007});
        chk("R7 second data", {24'b0, mw_data[1]}, 32'hC3);
    endtask

    task automatic t_read();
        logic [31:0] v;
        preload(8'h40, 8'h9E);
        hw(3'd1, 32'h0040);
        hw(3'd0, 32'h2);
        wait_idle("R2 read");
        hr(3'd2, v);
        chk("R2 data loaded from EEPROM", v, 32'h9E);
    endtask

    task automatic t_write();
        logic [31:0] v;
        int w0;
        w0 = n_eewr;
        hw(3'd2, 32'h3C);
        hw(3'd1, 32'h0055);
        hw(3'd0, 32'h1);
        wait_idle("R3 write");
        chk("R3 one EEPROM write", n_eewr - w0, 32'd1);
        chk("R3 EEPROM byte written", {24'b0, emem[8'h55]}, 32'h3C);
        hw(3'd2, 32'h00);
        hw(3'd0, 32'h2);
        wait_idle("R2 readback");
        hr(3'd2, v);
        chk("R2 readback of written byte", v, 32'h3C);
    endtask

    task automatic t_burst_continue();
        preload(8'h56, 8'h10); preload(8'h57, 8'h00); preload(8'h58, 8'h77);
        preload(8'h59, 8'hFF); preload(8'h5A, 8'hFF);
        hw(3'd3, 32'h0F3);
        mw_n = 0;
        got_first = 0; grab_first = 1;
        hw(3'd4, 32'h1);
        wait_idle("R6 burst");
        grab_first = 0;
        chk("R6 burst resumes after last access", {16'b0, first_addr}, 32'h56);
        chk("R7 memory write count", mw_n, 32'd1);
        chk("R7 address from new base", {8'b0, mw_addr[0]}, {8'b0, 9'h0F3, 15'h0010});
        chk("R7 data", {24'b0, mw_data[0]}, 32'h77);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        int w0, a0;
        preload(8'h30, 8'hAB);
        hw(3'd1, 32'h0030);
        lat = 20;
        w0 = n_eewr; a0 = n_ack; mw_n = 0;
        hw(3'd0, 32'h2);
        hr(3'd0, v);
        chk("R8 control shows read pending", v, 32'h2);
        hw(3'd0, 32'h1);
        hw(3'd4, 32'h1);
        hr(3'd4, v);
        chk("R8 start ignored while busy", v, 32'h0);
        wait_idle("R8 busy");
        lat = 2;
        repeat (10) @(negedge clk);
        chk("R8 dropped write made no EEPROM write", n_eewr - w0, 32'd0);
        chk("R8 only one transfer", n_ack - a0, 32'd1);
        chk("R8 dropped start made no memory write", mw_n, 32'd0);
        hr(3'd2, v);
        chk("R8 read completed", v, 32'hAB);
    endtask

    task automatic t_both();
        logic [31:0] v;
        int w0;
        preload(8'h41, 8'h11);
        hw(3'd2, 32'hEE);
        hw(3'd1, 32'h0041);
        w0 = n_eewr;
        hw(3'd0, 32'h3);
        wait_idle("R9 both");
        repeat (5) @(negedge clk);
        chk("R9 no EEPROM write", n_eewr - w0, 32'd0);
        chk("R9 EEPROM byte untouched", {24'b0, emem[8'h41]}, 32'h11);
        hr(3'd2, v);
        chk("R9 read performed", v, 32'h11);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) emem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_burst_from_zero();
        t_read();
        t_write();
        t_burst_continue();
        t_busy();
        t_both();
        chk("R4 request held steady until acknowledge", hs_err, 32'd0);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule